// File: doc/BRIEF.md
# Text Display Card Bus Interface

This block joins a processor bus with a 20-bit address to a character display card. It turns the top address nibble into one of sixteen card-select lines. Inside the segment of the display card it maps a 1 KB character memory of 64 columns by 16 rows, indexed by the low ten address bits. The memory is modelled here as a single-port synchronous array. The processor and the video fetch path share it, and the processor always wins. When a processor memory strobe hits the window, the RAM address switches to the processor at once, and the video side gets the memory back as soon as the strobe drops.

When the video side asks for a byte while the processor holds the memory, it gets nothing new. The block repeats the byte it delivered last and raises a collision flag for that cycle, so the pixel path shows the artifact the same way every time. One I/O port number serves two registers. A write to the port sets or clears the double-width display flag. A read from the port returns the option jumper bits.

Top module: `txt_display_bus`

## Requirements
- R1: `card_sel` is always the one-hot decode of `cpu_addr[19:16]`, so bit n is high exactly when that nibble equals n. It follows the address in the same cycle.
- R2: A memory strobe reaches the character memory only when `cpu_addr` lies in 0xFBC00..0xFBFFF, and the cell index is `cpu_addr[9:0]`. Writes to any other address, including the same low bits in another card's segment, leave the memory unchanged.
- R3: A window write (`mem_wr`) stores `cpu_wdata`. A window read (`mem_rd` without `mem_wr`) puts the stored byte on `cpu_rdata` with `cpu_rdata_oe` high in the cycle after the strobe. In any cycle with no valid read, `cpu_rdata_oe` is low and `cpu_rdata` is zero.
- R4: `ram_cpu_own` is high in the same cycle as any window memory strobe, whatever `vid_req` is doing, and low otherwise.
- R5: When `vid_req` is high and the processor does not own the memory, `vid_data` shows the byte at `vid_addr` in the next cycle, and `vid_collide` is low.
- R6: When `vid_req` is high while the processor owns the memory, the next cycle repeats the previous `vid_data` and raises `vid_collide`. When `vid_req` is low, `vid_data` holds and `vid_collide` is low.
- R7: An I/O write (`io_wr`) with `cpu_addr[7:0]` equal to 32 loads `cpu_wdata[1]` into `wide_mode` for the next cycle (1 = double width). I/O writes to any other port number leave `wide_mode` unchanged.
- R8: An I/O read (`io_rd`) with `cpu_addr[7:0]` equal to 32 returns `opt_sw` on `cpu_rdata` with `cpu_rdata_oe` high in the next cycle. An I/O read of any other port leaves `cpu_rdata_oe` low.
- R9: Reset (`rst_n` low) clears `wide_mode`, `cpu_rdata_oe`, `cpu_rdata`, `vid_data` and `vid_collide`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 20 | Processor address (memory address, or I/O port in bits 7:0) |
| cpu_wdata | input | 8 | Processor write data |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| opt_sw | input | 8 | Option jumper bits |
| vid_req | input | 1 | Video fetch request |
| vid_addr | input | 10 | Video fetch cell index |
| card_sel | output | 16 | One-hot card select |
| ram_cpu_own | output | 1 | Processor holds the character memory this cycle |
| cpu_rdata | output | 8 | Read data, one cycle after the strobe |
| cpu_rdata_oe | output | 1 | Read data valid / data bus drive enable |
| vid_data | output | 8 | Fetched character byte for the video path |
| vid_collide | output | 1 | Last video fetch was overridden by the processor |
| wide_mode | output | 1 | Double-width display flag |

## Verification
The memory is filled through the processor port with an index-dependent pattern. It is then read back at both ends and at the middle, which separates index wiring faults from data faults. Writes aimed just below, just above and at the same low bits in another segment show whether the window decode is too wide. Video fetches run three ways: alone, overlapping a processor write (the held byte and the collision flag must appear, then the new byte on the next free fetch), and idle. The port is driven with bit 1 set, bit 1 clear with every other bit set, and a neighbouring port number, so that a decoder using the wrong bit or the wrong port is caught.

// File: rtl/txt_bus_pkg.sv
package txt_bus_pkg;

  typedef enum logic {
    OWN_VIDEO = 1'b0,
    OWN_CPU   = 1'b1
  } ram_owner_e;

  // Window test: true when the address bits above the window size match the base.
  function automatic logic in_window(input logic [19:0] addr,
                                     input logic [19:0] base,
                                     input int unsigned idx_bits);
    return (addr >> idx_bits) == (base >> idx_bits);
  endfunction

  // Port match on the low byte of the address.
  function automatic logic port_match(input logic [7:0] low,
                                      input logic [7:0] port);
    return low == port;
  endfunction

endpackage

// File: rtl/txt_card_decode.sv
module txt_card_decode #(
  parameter int SEL_BITS = 4,
  localparam int LINES = 1 << SEL_BITS
) (
  input  logic [SEL_BITS-1:0] nibble,
  output logic [LINES-1:0]    sel
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign sel[g] = (nibble == SEL_BITS'(g));
  end

endmodule

// File: rtl/txt_char_ram.sv
module txt_char_ram #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    rdata <= cells[addr];
    if (we) cells[addr] <= wdata;
  end

endmodule

// File: rtl/txt_mode_port.sv
module txt_mode_port #(
  parameter int          PORT_W   = 8,
  parameter logic [7:0]  PORT_NUM = 8'd32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              mode_in,
  output logic              rd_hit,
  output logic              wide
);
  import txt_bus_pkg::*;

  logic match;
  assign match  = port_match(8'(port_addr), PORT_NUM);
  assign rd_hit = io_rd & match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wide <= 1'b0;
    else if (io_wr && match) wide <= mode_in;
  end

endmodule

// File: rtl/txt_display_bus.sv
module txt_display_bus #(
  parameter int          ADDR_W   = 20,
  parameter int          DATA_W   = 8,
  parameter int          DEPTH    = 1024,
  parameter int          SEL_BITS = 4,
  parameter logic [19:0] WIN_BASE = 20'hFBC00,
  parameter logic [7:0]  IO_PORT  = 8'd32,
  parameter int          MODE_BIT = 1,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LINES = 1 << SEL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] opt_sw,
  input  logic              vid_req,
  input  logic [IDX_W-1:0]  vid_addr,
  output logic [LINES-1:0]  card_sel,
  output logic              ram_cpu_own,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic [DATA_W-1:0] vid_data,
  output logic              vid_collide,
  output logic              wide_mode
);
  import txt_bus_pkg::*;

  // Named internal events, also used by the checker.
  logic              win_hit;
  logic              cpu_take;
  logic              vid_fetch;
  logic              mem_read_ev;
  logic              io_read_ev;
  ram_owner_e        owner;
  logic [IDX_W-1:0]  ram_addr;
  logic [DATA_W-1:0] ram_q;

  txt_card_decode #(.SEL_BITS(SEL_BITS)) u_dec (
    .nibble (cpu_addr[ADDR_W-1 -: SEL_BITS]),
    .sel    (card_sel)
  );

  assign win_hit     = in_window(20'(cpu_addr), WIN_BASE, IDX_W);
  assign cpu_take    = win_hit & (mem_rd | mem_wr);
  assign owner       = cpu_take ? OWN_CPU : OWN_VIDEO;
  assign ram_cpu_own = (owner == OWN_CPU);
  assign vid_fetch   = vid_req & ~cpu_take;
  assign mem_read_ev = cpu_take & mem_rd & ~mem_wr;
  assign ram_addr    = (owner == OWN_CPU) ? cpu_addr[IDX_W-1:0] : vid_addr;

  txt_char_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (cpu_take & mem_wr),
    .addr  (ram_addr),
    .wdata (cpu_wdata),
    .rdata (ram_q)
  );

  txt_mode_port #(.PORT_W(8), .PORT_NUM(IO_PORT)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_addr (cpu_addr[7:0]),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .mode_in   (cpu_wdata[MODE_BIT]),
    .rd_hit    (io_read_ev),
    .wide      (wide_mode)
  );

  logic              rd_mem_q, rd_io_q, fetch_q, collide_q;
  logic [DATA_W-1:0] opt_q, vid_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mem_q  <= 1'b0;
      rd_io_q   <= 1'b0;
      opt_q     <= '0;
      fetch_q   <= 1'b0;
      collide_q <= 1'b0;
      vid_hold  <= '0;
    end else begin
      rd_mem_q  <= mem_read_ev;
      rd_io_q   <= io_read_ev & ~mem_read_ev;
      opt_q     <= opt_sw;
      fetch_q   <= vid_fetch;
      collide_q <= vid_req & cpu_take;
      vid_hold  <= vid_data;
    end
  end

  assign cpu_rdata    = rd_mem_q ? ram_q : (rd_io_q ? opt_q : '0);
  assign cpu_rdata_oe = rd_mem_q | rd_io_q;
  assign vid_data     = fetch_q ? ram_q : vid_hold;
  assign vid_collide  = collide_q;

endmodule

// File: rtl/txt_display_bus_chk.sv
module txt_display_bus_chk #(
  parameter int LINES   = 16,
  parameter int CARD_ID = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] card_sel,
  input logic             ram_cpu_own,
  input logic             mem_rd,
  input logic             io_rd,
  input logic             io_wr,
  input logic             vid_req,
  input logic [7:0]       vid_data,
  input logic             vid_collide,
  input logic             cpu_rdata_oe,
  input logic [7:0]       cpu_rdata,
  input logic             wide_mode
);

  // R1
  card_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(card_sel) == 1);

  // R4
  own_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cpu_own |-> card_sel[CARD_ID]);

  // R6
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req && ram_cpu_own) |=> (vid_collide && $stable(vid_data)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_req |=> (!vid_collide && $stable(vid_data)));

  // R3
  oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata_oe |-> $past(mem_rd || io_rd));

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rdata_oe |-> (cpu_rdata == 8'h00));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(wide_mode));

endmodule

bind txt_display_bus txt_display_bus_chk #(.LINES(LINES), .CARD_ID(LINES-1)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .card_sel     (card_sel),
  .ram_cpu_own  (ram_cpu_own),
  .mem_rd       (mem_rd),
  .io_rd        (io_rd),
  .io_wr        (io_wr),
  .vid_req      (vid_req),
  .vid_data     (vid_data),
  .vid_collide  (vid_collide),
  .cpu_rdata_oe (cpu_rdata_oe),
  .cpu_rdata    (cpu_rdata),
  .wide_mode    (wide_mode)
);

// File: tb/txt_display_bus_test.sv
module txt_display_bus_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        mem_rd = 0, mem_wr = 0, io_rd = 0, io_wr = 0, vid_req = 0;
  logic [7:0]  opt_sw = '0;
  logic [9:0]  vid_addr = '0;
  logic [15:0] card_sel;
  logic        ram_cpu_own, cpu_rdata_oe, vid_collide, wide_mode;
  logic [7:0]  cpu_rdata, vid_data;

  txt_display_bus uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .opt_sw(opt_sw), .vid_req(vid_req), .vid_addr(vid_addr),
    .card_sel(card_sel), .ram_cpu_own(ram_cpu_own), .cpu_rdata(cpu_rdata),
    .cpu_rdata_oe(cpu_rdata_oe), .vid_data(vid_data),
    .vid_collide(vid_collide), .wide_mode(wide_mode)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  string rd_tag = "R3";

  // Behavioural reference model
  logic [7:0] ref_mem [0:1023];
  logic [7:0] e_rdata, e_vid;
  logic       e_oe, e_coll, e_wide, e_io;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_rdata = 0; e_oe = 0; e_vid = 0; e_coll = 0; e_wide = 0; e_io = 0;
    end else begin
      bit hit, own;
      hit = (cpu_addr >= 20'hFBC00) && (cpu_addr <= 20'hFBFFF);
      own = hit && (mem_rd || mem_wr);
      e_io = 0;
      if (own && mem_rd && !mem_wr) begin
        e_rdata = ref_mem[cpu_addr % 1024]; e_oe = 1;
      end else if (io_rd && cpu_addr[7:0] == 8'd32) begin
        e_rdata = opt_sw; e_oe = 1; e_io = 1;
      end else begin
        e_rdata = 0; e_oe = 0;
      end
      if (vid_req && !own) begin
        e_vid = ref_mem[vid_addr]; e_coll = 0;
      end else begin
        e_coll = vid_req;
      end
      if (io_wr && cpu_addr[7:0] == 8'd32) e_wide = cpu_wdata[1];
      if (own && mem_wr) ref_mem[cpu_addr % 1024] = cpu_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Registered outputs compared every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk(e_io ? "R8 oe" : {rd_tag, " oe"}, cpu_rdata_oe, e_oe);
      chk(e_io ? "R8 data" : {rd_tag, " data"}, cpu_rdata, e_rdata);
      chk("R5 vid_data", vid_data, e_vid);
      chk("R6 vid_collide", vid_collide, e_coll);
      chk("R7 wide_mode", wide_mode, e_wide);
    end
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input logic [19:0] a, input logic [7:0] d,
                     input bit mr, input bit mw, input bit ir, input bit iw,
                     input bit vr, input logic [9:0] va);
    bit hit;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; mem_rd = mr; mem_wr = mw;
    io_rd = ir; io_wr = iw; vid_req = vr; vid_addr = va;
    #1;
    hit = (a >= 20'hFBC00) && (a <= 20'hFBFFF);
    chk("R1 card_sel", card_sel, 16'(1) << a[19:16]);
    chk("R4 ram_cpu_own", ram_cpu_own, int'(hit && (mr || mw)));
  endtask

  task automatic idle();
    cyc(20'h0, 8'h0, 0, 0, 0, 0, 0, 10'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9 wide_mode", wide_mode, 0);
    chk("R9 oe", cpu_rdata_oe, 0);
    chk("R9 rdata", cpu_rdata, 0);
    chk("R9 vid_data", vid_data, 0);
    chk("R9 vid_collide", vid_collide, 0);
    rst_n = 1'b1;

    // R3: fill the window through the processor port
    for (int i = 0; i < 1024; i++)
      cyc(20'hFBC00 + 20'(i), 8'((i * 37 + 5) ^ (i >> 3)), 0, 1, 0, 0, 0, 10'h0);
    cyc(20'hFBC00, 0, 1, 0, 0, 0, 0, 0);
    cyc(20'hFBFFF, 0, 1, 0, 0, 0, 0, 0);
    cyc(20'hFBE00, 0, 1, 0, 0, 0, 0, 0);
    idle();

    // R2: writes outside the window must not land
    rd_tag = "R2";
    cyc(20'hFB800, 8'hAA, 0, 1, 0, 0, 0, 0);
    cyc(20'hFBBFF, 8'hAA, 0, 1, 0, 0, 0, 0);
    cyc(20'hFC000, 8'hAA, 0, 1, 0, 0, 0, 0);
    cyc(20'hEBC00, 8'hAA, 0, 1, 0, 0, 0, 0);
    cyc(20'h7BFFF, 8'hAA, 0, 1, 0, 0, 0, 0);
    cyc(20'hFBC00, 0, 1, 0, 0, 0, 0, 0);
    cyc(20'hFBFFF, 0, 1, 0, 0, 0, 0, 0);
    cyc(20'hEBC00, 0, 1, 0, 0, 0, 0, 0);
    idle();
    rd_tag = "R3";

    // R5: video fetches with a free memory
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 0, 0, 1, 10'(i * 67));
    idle();

    // R6: fetch overridden by processor write, then refetch same cell
    cyc(0, 0, 0, 0, 0, 0, 1, 10'd100);
    cyc(20'hFBC64, 8'h3C, 0, 1, 0, 0, 1, 10'd100);
    cyc(20'hFBC65, 8'h00, 1, 0, 0, 0, 1, 10'd100);
    cyc(0, 0, 0, 0, 0, 0, 1, 10'd100);
    cyc(0, 0, 0, 0, 0, 0, 0, 10'd5);
    cyc(0, 0, 0, 0, 0, 0, 0, 10'd6);
    // outside-window strobe does not block the video side (R4, R5)
    cyc(20'hFB800, 8'h11, 0, 1, 0, 0, 1, 10'd7);
    idle();

    // R7: mode port
    cyc(20'h00020, 8'h02, 0, 0, 0, 1, 0, 0);
    cyc(20'h00021, 8'h00, 0, 0, 0, 1, 0, 0);
    cyc(20'h00020, 8'hFD, 0, 0, 0, 1, 0, 0);
    cyc(20'h00020, 8'h02, 0, 0, 0, 0, 0, 0);
    cyc(20'h00020, 8'hFF, 0, 0, 0, 1, 0, 0);
    idle();

    // R8: option port reads
    opt_sw = 8'h5A;
    cyc(20'h00020, 0, 0, 0, 1, 0, 0, 0);
    cyc(20'h0001F, 0, 0, 0, 1, 0, 0, 0);
    opt_sw = 8'hC3;
    cyc(20'h00020, 0, 0, 0, 1, 0, 0, 0);
    idle();
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule